// File: doc/BRIEF.md
# Posted Store Queue with Double-Word Split

This block decouples an instruction pipeline from the memory cycles of its stores. The issuing side pushes a store and continues at once. The queue keeps the data word, the two low address bits and a type code for each word. The memory controller reads the oldest entry when it needs store data, and its request removes that entry in the same clock.

A double-word store arrives as a single push that carries two data words. The queue splits it into two consecutive entries: the first register's word, then the paired register's word. Both entries carry the same address bits and the same type code.

The queue accepts a push only when it has room for every entry that push creates. Entries leave strictly oldest first. A request against an empty queue is ignored and is recorded in a flag that stays set until reset.

Top module: `store_post_fifo`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty: empty=1, full=0, head_valid=0, underflow=0, and push_ready=1 for both single and double pushes.
- R2: A single push accepted at a clock edge stores push_data0, push_lsb and push_kind unchanged as one entry. If the queue was empty and no pop was taken, that entry appears on head_data, head_lsb and head_kind after that edge.
- R3: An accepted double push (push_dbl=1) creates two entries. The older entry holds push_data0 and the younger holds push_data1, and both carry the same push_lsb and push_kind.
- R4: Entries leave in strict first-in first-out order. The two words of a double push are never separated or swapped.
- R5: When pop_req is high at a clock edge and the queue is not empty, the head entry is removed at that edge. While no pop is taken, the head outputs hold their value.
- R6: push_ready is high when the free slots, counted before any pop in the same cycle, number at least 1 for a single push or at least 2 for a double push. A push presented while push_ready is low creates no entry.
- R7: A push and a pop taken at the same edge both take effect, and the occupancy afterwards equals the old occupancy plus the pushed entries minus one.
- R8: full is high exactly when DEPTH entries are held (DEPTH=4 by default). empty is high exactly when none are held, and head_valid is the inverse of empty.
- R9: A pop request while the queue is empty changes no entry and no pointer. It sets underflow after that edge, and underflow then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Store presented for queuing |
| push_dbl | input | 1 | Store is a double word (two entries) |
| push_data0 | input | 32 | First data word |
| push_data1 | input | 32 | Second data word, used only for a double push |
| push_lsb | input | 2 | Address bits 1:0 of the store |
| push_kind | input | 3 | Data type code, stored unchanged |
| push_ready | output | 1 | Room exists for the presented push |
| head_valid | output | 1 | An entry is at the head |
| head_data | output | 32 | Data word of the oldest entry |
| head_lsb | output | 2 | Address bits of the oldest entry |
| head_kind | output | 3 | Type code of the oldest entry |
| pop_req | input | 1 | Memory side takes and removes the head entry |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slots occupied |
| underflow | output | 1 | Sticky flag: a pop was requested while empty |

## Verification
push_ready depends on the registered occupancy and on the push_dbl input in the same cycle, so it is checked in the cycle the push is presented. Every push or pop shows on the head, full, empty and underflow outputs right after the edge that takes it, with no further register stage. The bench drives inputs on the falling edge, samples one time unit later, and then updates its scoreboard at the rising edge. Each comparison therefore sees exactly the state left by the previous rising edge.

// File: rtl/stq_pkg.sv
// Shared widths and entry layout for the posted store queue.
// Assumes the memory side handles byte placement; the queue only carries codes.
package stq_pkg;
    localparam int DATA_W = 32;
    localparam int LSB_W  = 2;
    localparam int KIND_W = 3;

    // One queued word with its control bits
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LSB_W-1:0]  lsb;
        logic [KIND_W-1:0] kind;
    } stq_entry_t;

    localparam int ENTRY_W = $bits(stq_entry_t);
endpackage

// File: rtl/stq_ctrl.sv
// Occupancy and pointer control for the posted store queue.
// Computes push acceptance (one or two slots), pop acceptance, write
// pointers for both words of a double push, and the sticky underflow flag.
// Assumes DEPTH >= 2 so a double push can ever fit.
module stq_ctrl #(
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_valid,
    input  logic                      push_dbl,
    input  logic                      pop_req,
    output logic                      push_ready,
    output logic                      wr_en0,
    output logic                      wr_en1,
    output logic [$clog2(DEPTH)-1:0]  wr_ptr0,
    output logic [$clog2(DEPTH)-1:0]  wr_ptr1,
    output logic [$clog2(DEPTH)-1:0]  rd_ptr,
    output logic                      full,
    output logic                      empty,
    output logic                      underflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] free_slots;
    logic [CNT_W-1:0] n_push;
    logic [CNT_W-1:0] n_pop;
    logic [PTR_W-1:0] wr_ptr;
    logic             push_acc;
    logic             pop_acc;

    // Advance a slot index with wrap at DEPTH
    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Acceptance decisions from registered occupancy
    always_comb begin
        free_slots = CNT_W'(DEPTH) - count;
        push_ready = push_dbl ? (free_slots >= CNT_W'(2)) : (free_slots >= CNT_W'(1));
        push_acc   = push_valid & push_ready;
        pop_acc    = pop_req & ~empty;
        n_push     = push_acc ? (push_dbl ? CNT_W'(2) : CNT_W'(1)) : '0;
        n_pop      = pop_acc ? CNT_W'(1) : '0;
    end

    // Write strobes and slot addresses for both words
    always_comb begin
        wr_ptr0 = wr_ptr;
        wr_ptr1 = ptr_inc(wr_ptr);
        wr_en0  = push_acc;
        wr_en1  = push_acc & push_dbl;
    end

    // Status flags from occupancy
    always_comb begin
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

    // Occupancy and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count + n_push - n_pop;
            if (push_acc)
                wr_ptr <= push_dbl ? ptr_inc(ptr_inc(wr_ptr)) : ptr_inc(wr_ptr);
            if (pop_acc)
                rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    // Sticky record of a pop against an empty queue
    always_ff @(posedge clk) begin
        if (!rst_n)
            underflow <= 1'b0;
        else if (pop_req && empty)
            underflow <= 1'b1;
    end

    // R8
    occupancy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_valid) |=> (underflow && empty && $stable(rd_ptr)));

    // R7
    push_pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !push_dbl && pop_req && !empty) |=> $stable(count));
endmodule

// File: rtl/stq_store.sv
// Entry storage for the posted store queue.
// Writes up to two entries per cycle at distinct slots (the second only for
// a double push) and presents the slot selected by the read pointer.
// Assumes the controller never points both write ports at the same slot.
module stq_store
    import stq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en0,
    input  logic                      wr_en1,
    input  logic [$clog2(DEPTH)-1:0]  wr_ptr0,
    input  logic [$clog2(DEPTH)-1:0]  wr_ptr1,
    input  stq_entry_t                wr_entry0,
    input  stq_entry_t                wr_entry1,
    input  logic [$clog2(DEPTH)-1:0]  rd_ptr,
    output stq_entry_t                rd_entry
);
    localparam int PTR_W = $clog2(DEPTH);

    stq_entry_t slots [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            logic hit0;
            logic hit1;
            // Decode which write port, if any, targets this slot
            always_comb begin
                hit0 = wr_en0 && (wr_ptr0 == PTR_W'(i));
                hit1 = wr_en1 && (wr_ptr1 == PTR_W'(i));
            end
            // Slot register update
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slots[i] <= '0;
                else if (hit0)
                    slots[i] <= wr_entry0;
                else if (hit1)
                    slots[i] <= wr_entry1;
            end
        end
    endgenerate

    // Head read mux
    always_comb rd_entry = slots[rd_ptr];

    // R3
    split_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en0 && wr_en1) |-> (wr_ptr0 != wr_ptr1));
endmodule

// File: rtl/store_post_fifo.sv
// Posted store queue: accepts single or double-word stores from the issue
// side and releases them one word at a time on memory-side request.
// A double push becomes two entries sharing address bits and type code.
// Assumes the memory side aligns data itself.
module store_post_fifo
    import stq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic              push_dbl,
    input  logic [31:0]       push_data0,
    input  logic [31:0]       push_data1,
    input  logic [1:0]        push_lsb,
    input  logic [2:0]        push_kind,
    output logic              push_ready,
    output logic              head_valid,
    output logic [31:0]       head_data,
    output logic [1:0]        head_lsb,
    output logic [2:0]        head_kind,
    input  logic              pop_req,
    output logic              full,
    output logic              empty,
    output logic              underflow
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             wr_en0;
    logic             wr_en1;
    logic [PTR_W-1:0] wr_ptr0;
    logic [PTR_W-1:0] wr_ptr1;
    logic [PTR_W-1:0] rd_ptr;
    stq_entry_t       entry0;
    stq_entry_t       entry1;
    stq_entry_t       head;

    // Build both entries from one push; control bits are shared
    always_comb begin
        entry0.data = push_data0;
        entry0.lsb  = push_lsb;
        entry0.kind = push_kind;
        entry1.data = push_data1;
        entry1.lsb  = push_lsb;
        entry1.kind = push_kind;
    end

    stq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_dbl   (push_dbl),
        .pop_req    (pop_req),
        .push_ready (push_ready),
        .wr_en0     (wr_en0),
        .wr_en1     (wr_en1),
        .wr_ptr0    (wr_ptr0),
        .wr_ptr1    (wr_ptr1),
        .rd_ptr     (rd_ptr),
        .full       (full),
        .empty      (empty),
        .underflow  (underflow)
    );

    stq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en0    (wr_en0),
        .wr_en1    (wr_en1),
        .wr_ptr0   (wr_ptr0),
        .wr_ptr1   (wr_ptr1),
        .wr_entry0 (entry0),
        .wr_entry1 (entry1),
        .rd_ptr    (rd_ptr),
        .rd_entry  (head)
    );

    // Head outputs straight from the selected slot
    always_comb begin
        head_valid = ~empty;
        head_data  = head.data;
        head_lsb   = head.lsb;
        head_kind  = head.kind;
    end

    // R6
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push_ready);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !pop_req) |=> (head_valid && $stable(head_data) && $stable(head_kind)));

    // R2
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && empty && !pop_req) |=>
            (head_data == $past(push_data0) && head_lsb == $past(push_lsb)));
endmodule

// File: tb/store_post_fifo_test.sv
module store_post_fifo_test;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic        push_dbl = 1'b0;
    logic [31:0] push_data0 = '0;
    logic [31:0] push_data1 = '0;
    logic [1:0]  push_lsb = '0;
    logic [2:0]  push_kind = '0;
    logic        pop_req = 1'b0;
    logic        push_ready, head_valid, full, empty, underflow;
    logic [31:0] head_data;
    logic [1:0]  head_lsb;
    logic [2:0]  head_kind;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    // scoreboard entries: {data, lsb, kind}
    logic [36:0] sb[$];
    bit          uf_model = 1'b0;

    always #5 clk = ~clk;

    store_post_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_dbl(push_dbl),
        .push_data0(push_data0), .push_data1(push_data1), .push_lsb(push_lsb),
        .push_kind(push_kind), .push_ready(push_ready), .head_valid(head_valid),
        .head_data(head_data), .head_lsb(head_lsb), .head_kind(head_kind),
        .pop_req(pop_req), .full(full), .empty(empty), .underflow(underflow)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compares outputs with the scoreboard state
    task automatic monitor(input bit dbl_now);
        int need;
        need = dbl_now ? 2 : 1;
        chk("R6 push_ready", push_ready, (sb.size() + need <= DEPTH));
        chk("R8 empty", empty, (sb.size() == 0));
        chk("R8 full", full, (sb.size() == DEPTH));
        chk("R8 head_valid", head_valid, (sb.size() != 0));
        chk("R9 underflow", underflow, uf_model);
        if (sb.size() != 0) begin
            chk("R4 head data", head_data, sb[0][36:5]);
            chk("R3 head lsb", head_lsb, sb[0][4:3]);
            chk("R2 head kind", head_kind, sb[0][2:0]);
        end
    endtask

    // Driver: one cycle of stimulus, then scoreboard update at the edge
    task automatic step(input bit pv, input bit pd, input logic [31:0] d0,
                        input logic [31:0] d1, input logic [1:0] l,
                        input logic [2:0] k, input bit pp);
        bit acc;
        bit popt;
        @(negedge clk);
        push_valid = pv; push_dbl = pd; push_data0 = d0; push_data1 = d1;
        push_lsb = l; push_kind = k; pop_req = pp;
        #1;
        monitor(pd);
        acc  = pv && (sb.size() + (pd ? 2 : 1) <= DEPTH);
        popt = pp && (sb.size() != 0);
        @(posedge clk);
        if (pp && sb.size() == 0) uf_model = 1'b1;
        if (popt) void'(sb.pop_front());
        if (acc) begin
            sb.push_back({d0, l, k});
            if (pd) sb.push_back({d1, l, k});
        end
    endtask

    task automatic idle();
        step(0, 0, '0, '0, '0, '0, 0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 empty", empty, 1'b1);
        chk("R1 full", full, 1'b0);
        chk("R1 head_valid", head_valid, 1'b0);
        chk("R1 underflow", underflow, 1'b0);
        chk("R1 push_ready", push_ready, 1'b1);
        push_dbl = 1'b1; #1;
        chk("R1 push_ready dbl", push_ready, 1'b1);

        // R2 single push, then R5 hold and pop
        step(1, 0, 32'hA1B2C3D4, 32'h0, 2'd3, 3'd1, 0);
        idle();
        idle();
        step(0, 0, '0, '0, '0, '0, 1);
        idle();

        // R3 double push splits into two words with shared control
        step(1, 1, 32'h11111111, 32'h22222222, 2'd0, 3'd5, 0);
        idle();
        step(0, 0, '0, '0, '0, '0, 1);
        step(0, 0, '0, '0, '0, '0, 1);
        idle();

        // R4 mixed order, R6 refusal when space runs short
        step(1, 0, 32'h00000001, '0, 2'd1, 3'd0, 0);
        step(1, 1, 32'h00000002, 32'h00000003, 2'd2, 3'd5, 0);
        step(1, 1, 32'hDEADBEEF, 32'hBADBAD00, 2'd0, 3'd5, 0);   // 3 held: refused
        step(1, 0, 32'h00000004, '0, 2'd3, 3'd3, 0);             // fills to 4
        step(1, 0, 32'hFFFFFFFF, '0, 2'd0, 3'd4, 1);             // full: refused, pop taken
        // R7 push with pop at 3 held keeps count at 3
        step(1, 0, 32'h00000005, '0, 2'd1, 3'd2, 1);
        step(1, 0, 32'h00000006, '0, 2'd2, 3'd2, 0);             // back to full
        idle();
        repeat (4) step(0, 0, '0, '0, '0, '0, 1);
        idle();

        // R9 pop while empty, flag sticks
        step(0, 0, '0, '0, '0, '0, 1);
        idle();
        step(1, 0, 32'h0BADF00D, '0, 2'd2, 3'd4, 0);
        idle();
        step(0, 0, '0, '0, '0, '0, 1);
        idle();

        // Mixed traffic from an LFSR
        lfsr = 32'h1ACE5EED;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], lfsr[1], lfsr, ~lfsr, lfsr[3:2], lfsr[6:4], lfsr[7] & lfsr[8]);
        end
        repeat (6) step(0, 0, '0, '0, '0, '0, 1);
        idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule